// File: doc/BRIEF.md
# Pin Event Detector

The block watches a bank of already-synchronized digital pin inputs and, for each pin, looks for one condition chosen by a 4-bit mode code: a rising edge, a falling edge, either edge, a steady low or a steady high. When the chosen condition is seen, a sticky per-pin flag is set. The mode code also chooses where the flag goes. Pins in interrupt mode feed one shared interrupt line. Pins in transfer mode raise their own DMA request line.

Software clears flags by writing ones into a 32-bit status word. It can also clear one pin's flag through that pin's own configuration register, which arrives here as a strobe and a pin index. For transfer-mode pins, a per-pin completion pulse from the DMA engine clears the flag by itself. A level-mode pin whose level is still present sets its flag again on the edge after any clear. The current flags are presented as the status read value.

Top module: `pin_event_detect`

## Requirements
- R1: After reset every flag, the interrupt output and every DMA request read 0.
- R2: Edges are found by comparing each pin's sample with the sample taken on the previous clock edge. Code 4'b0001 (transfer) and code 4'b1001 (interrupt) set the flag on the clock edge where the pin is first sampled high after having been sampled low.
- R3: Codes 4'b0010 and 4'b1010 set the flag on a high-to-low change. Codes 4'b0011 and 4'b1011 set it on a change in either direction.
- R4: Code 4'b1000 sets the flag on every edge where the pin is sampled low. Code 4'b1100 sets it on every edge where the pin is sampled high. While that level persists, the flag reads 1 again on the edge after a clear.
- R5: Code 4'b0000 and every code not named in R2 to R4 never set a flag. A flag that is already set keeps its value.
- R6: When the status write strobe is high, each 1 in the 32-bit write data clears the flag with the same bit number. Each 0 leaves its flag unchanged.
- R7: When the pin-clear strobe is high, the flag of the pin selected by the 5-bit index is cleared. Other flags are untouched.
- R8: A DMA-done pulse on a pin clears its flag only while that pin's code is a transfer code (4'b0001 to 4'b0011). On other pins the pulse has no effect.
- R9: If a set condition and any clear fall on the same flag in the same cycle, the flag ends up set.
- R10: The interrupt output is the OR of all set flags of pins whose code is an interrupt code (4'b1000 to 4'b1011, 4'b1100).
- R11: Each DMA request output equals that pin's flag while the pin has a transfer code, and is 0 otherwise.
- R12: Each pin's previous sample resets to 0. A pin that is high through reset, under a rising-edge code, sets its flag on the first active clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 32 | Synchronized pin levels |
| mode_i | input | 128 | 4-bit mode code per pin; pin n uses bits 4n+3..4n |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 32 | Status write data; a 1 clears the flag with that bit number |
| pin_clr_i | input | 1 | Single-pin flag clear strobe |
| pin_idx_i | input | 5 | Pin selected by pin_clr_i |
| dma_done_i | input | 32 | Per-pin transfer completion pulses |
| flags_o | output | 32 | Current flags (status read value) |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 32 | Per-pin DMA requests |

## Verification
A condition sampled on a clock edge shows up in flags_o right after that same edge, so the result is due one cycle after the stimulus is driven. The same holds for clears and DMA-done pulses. irq_o and dma_req_o follow flags_o and the present mode codes with no extra register, and they change in that same cycle. Reset release passes through a two-stage synchronizer, so the bench counts two edges after release before the first active edge. Inputs are driven at the falling edge. A reference model steps once per rising edge, and every output is compared against it at the next falling edge.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [3:0] {
    EV_OFF      = 4'b0000,
    EV_DMA_RISE = 4'b0001,
    EV_DMA_FALL = 4'b0010,
    EV_DMA_BOTH = 4'b0011,
    EV_IRQ_LOW  = 4'b1000,
    EV_IRQ_RISE = 4'b1001,
    EV_IRQ_FALL = 4'b1010,
    EV_IRQ_BOTH = 4'b1011,
    EV_IRQ_HIGH = 4'b1100
  } ev_code_e;

  typedef struct packed {
    logic to_dma;
    logic to_irq;
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
  } ev_sel_t;

  function automatic ev_sel_t ev_decode(logic [3:0] code);
    ev_sel_t s;
    s = '0;
    case (code)
      EV_DMA_RISE: begin s.to_dma = 1'b1; s.on_rise = 1'b1; end
      EV_DMA_FALL: begin s.to_dma = 1'b1; s.on_fall = 1'b1; end
      EV_DMA_BOTH: begin s.to_dma = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
      EV_IRQ_LOW:  begin s.to_irq = 1'b1; s.on_low  = 1'b1; end
      EV_IRQ_RISE: begin s.to_irq = 1'b1; s.on_rise = 1'b1; end
      EV_IRQ_FALL: begin s.to_irq = 1'b1; s.on_fall = 1'b1; end
      EV_IRQ_BOTH: begin s.to_irq = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
      EV_IRQ_HIGH: begin s.to_irq = 1'b1; s.on_high = 1'b1; end
      default:     s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CODEW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*CODEW-1:0] mode_i,
  output logic [NPINS-1:0]       set_o,
  output logic [NPINS-1:0]       dma_mode_o,
  output logic [NPINS-1:0]       irq_mode_o
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  always_comb begin
    prev_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    ev_sel_t sel;
    logic    rise_w;
    logic    fall_w;
    assign sel    = ev_decode(mode_i[g*CODEW +: CODEW]);
    assign rise_w = pin_i[g] & ~prev_q[g];
    assign fall_w = ~pin_i[g] & prev_q[g];
    assign set_o[g] = (sel.on_rise & rise_w) | (sel.on_fall & fall_w) |
                      (sel.on_low & ~pin_i[g]) | (sel.on_high & pin_i[g]);
    assign dma_mode_o[g] = sel.to_dma;
    assign irq_mode_o[g] = sel.to_irq;

    // R2: a set caused by a rising-only code needs the previous sample low
    p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_o[g] && (mode_i[g*CODEW +: CODEW] == EV_IRQ_RISE)) |-> (prev_q[g] == 1'b0 && pin_i[g]));
  end

endmodule

// File: rtl/pin_evt_flags.sv
module pin_evt_flags #(
  parameter int NPINS = 32,
  parameter int IDXW  = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] dma_mode_i,
  input  logic             sts_wr_i,
  input  logic [NPINS-1:0] sts_wdata_i,
  input  logic             pin_clr_i,
  input  logic [IDXW-1:0]  pin_idx_i,
  input  logic [NPINS-1:0] dma_done_i,
  output logic [NPINS-1:0] flags_o
);

  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] flag_d;
  logic [NPINS-1:0] clr_w;
  logic             upd_en;

  for (genvar g = 0; g < NPINS; g++) begin : g_clr
    assign clr_w[g] = (sts_wr_i & sts_wdata_i[g]) |
                      (pin_clr_i & (pin_idx_i == IDXW'(g))) |
                      (dma_done_i[g] & dma_mode_i[g]);
  end

  always_comb begin
    upd_en = |(set_i | clr_w);
    flag_d = set_i | (flag_q & ~clr_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);
    p_w1c_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr_i && sts_wdata_i[g] && !set_i[g]) |=> !flag_q[g]);
    p_dma_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done_i[g] && dma_mode_i[g] && !set_i[g]) |=> !flag_q[g]);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !(sts_wr_i && sts_wdata_i[g]) && !pin_clr_i && !dma_done_i[g]) |=> flag_q[g]);
  end

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
  parameter int NPINS = 32,
  parameter int CODEW = 4,
  parameter int IDXW  = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*CODEW-1:0] mode_i,
  input  logic                   sts_wr_i,
  input  logic [NPINS-1:0]       sts_wdata_i,
  input  logic                   pin_clr_i,
  input  logic [IDXW-1:0]        pin_idx_i,
  input  logic [NPINS-1:0]       dma_done_i,
  output logic [NPINS-1:0]       flags_o,
  output logic                   irq_o,
  output logic [NPINS-1:0]       dma_req_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NPINS-1:0] set_w;
  logic [NPINS-1:0] dma_mode_w;
  logic [NPINS-1:0] irq_mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pin_evt_detect #(.NPINS(NPINS), .CODEW(CODEW)) u_detect (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_i      (pin_i),
    .mode_i     (mode_i),
    .set_o      (set_w),
    .dma_mode_o (dma_mode_w),
    .irq_mode_o (irq_mode_w)
  );

  pin_evt_flags #(.NPINS(NPINS), .IDXW(IDXW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .set_i       (set_w),
    .dma_mode_i  (dma_mode_w),
    .sts_wr_i    (sts_wr_i),
    .sts_wdata_i (sts_wdata_i),
    .pin_clr_i   (pin_clr_i),
    .pin_idx_i   (pin_idx_i),
    .dma_done_i  (dma_done_i),
    .flags_o     (flags_o)
  );

  assign irq_o     = |(flags_o & irq_mode_w);
  assign dma_req_o = flags_o & dma_mode_w;

  p_quiet_when_clear_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flags_o == '0) |-> (!irq_o && dma_req_o == '0));
  p_dma_irq_disjoint_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dma_req_o & irq_mode_w) == '0);

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    p_off_no_set_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
      (dma_mode_w[g] == 1'b0 && irq_mode_w[g] == 1'b0 && !flags_o[g]) |=> !flags_o[g]);
  end

endmodule

// File: tb/pin_event_detect_bench.sv
module pin_event_detect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  pin_i;
  logic [4*N-1:0] mode_i;
  logic          sts_wr_i;
  logic [N-1:0]  sts_wdata_i;
  logic          pin_clr_i;
  logic [4:0]    pin_idx_i;
  logic [N-1:0]  dma_done_i;
  logic [N-1:0]  flags_o;
  logic          irq_o;
  logic [N-1:0]  dma_req_o;

  int vectors;
  int misses;
  string req;
  bit prev_m [N];
  bit flag_m [N];
  bit flag_n [N];

  pin_event_detect u_pin_event_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_i),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .pin_clr_i(pin_clr_i),
    .pin_idx_i(pin_idx_i), .dma_done_i(dma_done_i), .flags_o(flags_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_dma(int c);
    return (c >= 1 && c <= 3);
  endfunction
  function automatic bit is_irq(int c);
    return (c >= 8 && c <= 12);
  endfunction

  function automatic int code_of(int i);
    return int'(mode_i[i*4 +: 4]);
  endfunction

  task automatic model_next();
    for (int i = 0; i < N; i++) begin
      int c = code_of(i);
      bit cur = pin_i[i];
      bit p = prev_m[i];
      bit s = 0;
      bit k;
      if ((c == 1 || c == 9 || c == 3 || c == 11) && cur && !p) s = 1;
      if ((c == 2 || c == 10 || c == 3 || c == 11) && !cur && p) s = 1;
      if (c == 8 && !cur) s = 1;
      if (c == 12 && cur) s = 1;
      k = (sts_wr_i && sts_wdata_i[i]) || (pin_clr_i && int'(pin_idx_i) == i) ||
          (dma_done_i[i] && is_dma(c));
      flag_n[i] = s ? 1'b1 : (k ? 1'b0 : flag_m[i]);
    end
  endtask

  task automatic compare();
    logic [N-1:0] ef;
    logic [N-1:0] ed;
    logic ei;
    ei = 0;
    for (int i = 0; i < N; i++) begin
      ef[i] = flag_m[i];
      ed[i] = flag_m[i] && is_dma(code_of(i));
      if (flag_m[i] && is_irq(code_of(i))) ei = 1;
    end
    vectors++;
    if (flags_o !== ef || dma_req_o !== ed || irq_o !== ei) begin
      misses++;
      $display("FAIL %s: flags %h dma %h irq %b, expected flags %h dma %h irq %b",
               req, flags_o, dma_req_o, irq_o, ef, ed, ei);
    end
  endtask

  task automatic tick();
    model_next();
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      flag_m[i] = flag_n[i];
      prev_m[i] = pin_i[i];
    end
    @(negedge clk);
    compare();
    sts_wr_i = 0; sts_wdata_i = '0; pin_clr_i = 0; dma_done_i = '0;
  endtask

  task automatic expect_bit(string r, int pin, bit exp_v);
    vectors++;
    if (flags_o[pin] !== exp_v) begin
      misses++;
      $display("FAIL %s: flag[%0d] = %b, expected %b", r, pin, flags_o[pin], exp_v);
    end
  endtask

  task automatic set_code(int pin, logic [3:0] c);
    mode_i[pin*4 +: 4] = c;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    vectors = 0; misses = 0; req = "R1";
    rst_n = 0; pin_i = '0; mode_i = '0; sts_wr_i = 0; sts_wdata_i = '0;
    pin_clr_i = 0; pin_idx_i = '0; dma_done_i = '0;
    for (int i = 0; i < N; i++) begin prev_m[i] = 0; flag_m[i] = 0; end
    // R12: pin 5 high through reset with a rising-edge interrupt code
    pin_i[5] = 1'b1;
    set_code(5, 4'b1001);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare();                         // R1 reset state
    expect_bit("R1", 5, 1'b0);
    req = "R12"; tick();
    expect_bit("R12", 5, 1'b1);
    vectors++;
    if (irq_o !== 1'b1) begin misses++; $display("FAIL R10: irq %b, expected 1", irq_o); end
    sts_wr_i = 1; sts_wdata_i = 32'h20; req = "R6"; tick();
    expect_bit("R6", 5, 1'b0);

    // R2 transfer rising edge on pin 1, R3 falling on pin 2 and both edges on pin 3
    set_code(1, 4'b0001); set_code(2, 4'b1010); set_code(3, 4'b0011);
    req = "R2"; tick();
    pin_i[1] = 1; pin_i[3] = 1; tick();
    expect_bit("R2", 1, 1'b1);
    expect_bit("R3", 3, 1'b1);
    vectors++;
    if (dma_req_o[1] !== 1'b1) begin misses++; $display("FAIL R11: dma_req[1] %b, expected 1", dma_req_o[1]); end
    dma_done_i[1] = 1; dma_done_i[3] = 1; req = "R8"; tick();
    expect_bit("R8", 1, 1'b0);
    pin_i[2] = 1; tick();
    pin_i[2] = 0; pin_i[3] = 0; req = "R3"; tick();
    expect_bit("R3", 2, 1'b1);
    expect_bit("R3", 3, 1'b1);
    // R8: done pulse on an interrupt-mode pin is ignored
    dma_done_i[2] = 1; req = "R8"; tick();
    expect_bit("R8", 2, 1'b1);
    // R6: writing 0 leaves flags alone
    sts_wr_i = 1; sts_wdata_i = 32'h0; req = "R6"; tick();
    expect_bit("R6", 2, 1'b1);
    // R7: single-pin clear
    pin_clr_i = 1; pin_idx_i = 5'd2; req = "R7"; tick();
    expect_bit("R7", 2, 1'b0);
    expect_bit("R7", 3, 1'b1);

    // R4 level codes, R9 set beats clear
    set_code(7, 4'b1100); set_code(8, 4'b1000); pin_i[7] = 1;
    req = "R4"; tick();
    expect_bit("R4", 7, 1'b1);
    expect_bit("R4", 8, 1'b1);
    sts_wr_i = 1; sts_wdata_i = 32'h180; req = "R9"; tick();
    expect_bit("R9", 7, 1'b1);
    expect_bit("R4", 8, 1'b1);
    pin_i[8] = 1; pin_clr_i = 1; pin_idx_i = 5'd8; req = "R4"; tick();
    expect_bit("R4", 8, 1'b0);

    // R5: disabled and unlisted codes never set
    set_code(10, 4'b0000); set_code(11, 4'b0101); set_code(12, 4'b1111);
    req = "R5";
    pin_i[10] = 1; pin_i[11] = 1; pin_i[12] = 1; tick();
    pin_i[10] = 0; pin_i[11] = 0; pin_i[12] = 0; tick();
    expect_bit("R5", 10, 1'b0);
    expect_bit("R5", 11, 1'b0);
    expect_bit("R5", 12, 1'b0);

    // Mixed run: random levels, codes and clears (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
    req = "R10/R11 mixed";
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc % 40 == 0) begin
        for (int i = 0; i < N; i++) begin
          int pick = $urandom_range(0, 11);
          logic [3:0] tbl [12] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h4, 4'h7, 4'hE};
          set_code(i, tbl[pick]);
        end
      end
      pin_i = pin_i ^ ($urandom() & $urandom());
      if ($urandom_range(0, 3) == 0) begin sts_wr_i = 1; sts_wdata_i = $urandom(); end
      if ($urandom_range(0, 3) == 0) begin pin_clr_i = 1; pin_idx_i = 5'($urandom()); end
      dma_done_i = $urandom() & $urandom();
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule